// File: doc/BRIEF.md
# Serial Frame Transmitter with Fault Injection

This block turns parallel bytes into serial character frames. A control byte picks between two modes. In the asynchronous mode, bits are timed by a 16x oversample tick. In the clocked synchronous mode, one bit is sent per transmit-clock period and the block drives that clock as well. In synchronous mode the clock comes from one of two places: a divided copy of the internal baud tick, or the port's receive clock after a two-flop synchronizer.

Two test bits in the control byte corrupt frames on purpose, so that a far-end receiver's error checks can be exercised:
- One test bit inverts the parity bit.
- The other test bit shortens the stop bit to half a bit in asynchronous mode, or leaves the stop bit out in synchronous mode.

Bytes enter through a valid/ready handshake. The control byte is captured when a byte is accepted, so the settings stay fixed for the whole frame.

The state machine has six states:
- IDLE: waits for an accepted byte.
- ALIGN: synchronous only; waits for the first falling transmit-clock edge.
- START, DATA, PARITY, STOP: send the frame bits.

Its transitions are:
- IDLE→START on accept in asynchronous mode.
- IDLE→ALIGN on accept in synchronous mode.
- ALIGN→START on a falling clock edge.
- START→DATA when the start bit ends.
- DATA→DATA between data bits.
- DATA→PARITY after the last data bit when parity is on.
- DATA→STOP after the last data bit when parity is off.
- DATA→IDLE or PARITY→IDLE when the stop bit is dropped.
- PARITY→STOP.
- STOP→IDLE.

Top module: `usart_tx_inject`

## Requirements
- R1: After reset, and whenever reset is applied mid-frame, the line is at mark (txd_o=1), tx_en_o=0, tx_clk_o=0, and an interrupted frame does not resume.
- R2: Control bit 7 is the enable. While it is 0, tx_ready_o stays 0, no frame starts, and the line stays at mark.
- R3: A frame is one start bit (0), then 8 data bits LSB first, then an optional parity bit, then one stop bit (1). Control bit 1 turns parity on. Control bit 2 selects odd parity (1) or even parity (0). Even parity makes the data bits plus the parity bit hold an even number of ones.
- R4: In asynchronous mode (control bit 0 = 0), the start bit begins at the clock edge that accepts the byte, and every bit lasts exactly 16 baud ticks.
- R5: tx_en_o is 1 from the start bit through the end of the last bit of the frame. Otherwise it is 0, and txd_o is 1 whenever tx_en_o is 0.
- R6: With control bit 5 set in asynchronous mode, the stop bit lasts 8 baud ticks. After that, the line is idle.
- R7: With control bit 5 set in synchronous mode, the frame ends after the last data bit, or after the parity bit when parity is on. No stop bit is sent.
- R8: With control bit 4 set, the parity bit is inverted from the value given by R3.
- R9: In synchronous mode (control bit 0 = 1), one bit is sent per tx_clk_o period. txd_o changes only together with a falling edge of tx_clk_o. The first bit follows the first falling edge after the byte is accepted. With control bit 3 = 0, tx_clk_o toggles on each baud tick.
- R10: With control bit 3 = 1 in synchronous mode, tx_clk_o follows rx_clk_i, delayed by 3 clk cycles, and the baud tick has no effect. In asynchronous mode, tx_clk_o is 0.
- R11: A byte is accepted only on a cycle where tx_valid_i and tx_ready_o are both 1. tx_ready_o is 1 only while the block is idle and enabled.
- R12: A change to cfg_i during a frame takes effect only at the next accepted byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_i | input | 8 | Control byte. Bit 7 enable, bit 6 reserved, bit 5 stop-bit fault, bit 4 parity fault, bit 3 clock from receive clock, bit 2 odd parity, bit 1 parity on, bit 0 synchronous mode |
| tx_data_i | input | DATA_W | Byte to send |
| tx_valid_i | input | 1 | A byte is offered |
| tx_ready_o | output | 1 | A byte can be accepted |
| baud_tick_i | input | 1 | One-cycle pulse from the baud divider |
| rx_clk_i | input | 1 | Port receive clock, asynchronous to clk |
| txd_o | output | 1 | Serial data out |
| tx_en_o | output | 1 | High while a frame is on the line |
| tx_clk_o | output | 1 | Transmit clock in synchronous mode |

## Verification
A bit counter or index that slips shows up at once as a frame whose bits are too long or too short, counted in baud ticks. It also shows up as a byte whose bits are shifted by one position, visible within the very next frame. A parity or stop decision taken from the wrong configuration shows up in the last one or two bits of that same frame. A clock-source or edge-selection fault causes txd_o to move while tx_clk_o is high, or the bits to arrive at the wrong rate, both within the first bit of a synchronous frame. A state machine stuck outside IDLE keeps tx_ready_o low, and the next offered byte is never accepted.

// File: rtl/usart_tx_pkg.sv
package usart_tx_pkg;

    // Control byte layout (bit 7 down to bit 0).
    typedef struct packed {
        logic enable;
        logic rsvd;
        logic fe_test;
        logic pe_test;
        logic clk_rx;
        logic odd_par;
        logic par_en;
        logic sync_mode;
    } cfg_t;

    // Settings frozen for one frame.
    typedef struct packed {
        logic sync_mode;
        logic fe_test;
        logic par_en;
        logic clk_rx;
    } frame_cfg_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ALIGN,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_e;

endpackage

// File: rtl/usart_tx_clkgen.sv
module usart_tx_clkgen #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic baud_tick_i,
    input  logic rx_clk_i,
    input  logic use_rx_i,
    output logic bit_clk_o,
    output logic fall_stb_o
);
    logic [SYNC_STAGES-1:0] rx_sync_q;
    logic                   gen_q;
    logic                   lvl_q;
    logic                   sel_lvl;

    // Synchronizer for the foreign receive clock, plus the local divided clock.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_sync_q <= '0;
            gen_q     <= 1'b0;
            lvl_q     <= 1'b0;
        end else begin
            rx_sync_q <= {rx_sync_q[SYNC_STAGES-2:0], rx_clk_i};
            if (baud_tick_i) begin
                gen_q <= ~gen_q;
            end
            lvl_q <= sel_lvl;
        end
    end

    assign sel_lvl    = use_rx_i ? rx_sync_q[SYNC_STAGES-1] : gen_q;
    assign fall_stb_o = lvl_q & ~sel_lvl;
    assign bit_clk_o  = lvl_q;

endmodule

// File: rtl/usart_tx_fsm.sv
module usart_tx_fsm
    import usart_tx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              sync_i,
    input  logic              fe_i,
    input  logic              pe_i,
    input  logic              odd_i,
    input  logic              par_en_i,
    input  logic              clk_rx_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              valid_i,
    output logic              ready_o,
    input  logic              baud_tick_i,
    input  logic              fall_stb_i,
    output logic              act_sync_o,
    output logic              act_clk_rx_o,
    output logic              txd_o,
    output logic              tx_en_o
);
    localparam int CNT_W = $clog2(OVS);
    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(OVS - 1);
    localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(OVS / 2 - 1);
    localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(DATA_W - 1);

    tx_state_e         state_q, state_d;
    frame_cfg_t        cfg_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] shreg_q;
    logic              par_q;
    logic              accept;
    logic              bit_done;
    logic              skip_stop;
    logic [CNT_W-1:0]  bit_last;

    assign ready_o   = (state_q == ST_IDLE) && en_i;
    assign accept    = valid_i && ready_o;
    assign bit_last  = (state_q == ST_STOP && cfg_q.fe_test) ? HALF_LAST : FULL_LAST;
    assign bit_done  = cfg_q.sync_mode ? fall_stb_i : (baud_tick_i && cnt_q == bit_last);
    assign skip_stop = cfg_q.sync_mode && cfg_q.fe_test;

    // Clock selection follows the live byte while idle, the frozen one in a frame.
    assign act_sync_o   = (state_q == ST_IDLE) ? sync_i   : cfg_q.sync_mode;
    assign act_clk_rx_o = (state_q == ST_IDLE) ? clk_rx_i : cfg_q.clk_rx;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept)     state_d = sync_i ? ST_ALIGN : ST_START;
            ST_ALIGN:  if (fall_stb_i) state_d = ST_START;
            ST_START:  if (bit_done)   state_d = ST_DATA;
            ST_DATA: begin
                if (bit_done && idx_q == IDX_LAST) begin
                    if (cfg_q.par_en)   state_d = ST_PARITY;
                    else if (skip_stop) state_d = ST_IDLE;
                    else                state_d = ST_STOP;
                end
            end
            ST_PARITY: if (bit_done)   state_d = skip_stop ? ST_IDLE : ST_STOP;
            ST_STOP:   if (bit_done)   state_d = ST_IDLE;
            default:                   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q   <= '0;
            cnt_q   <= '0;
            idx_q   <= '0;
            shreg_q <= '0;
            par_q   <= 1'b0;
        end else if (accept) begin
            cfg_q   <= '{sync_mode: sync_i, fe_test: fe_i, par_en: par_en_i, clk_rx: clk_rx_i};
            cnt_q   <= '0;
            idx_q   <= '0;
            shreg_q <= data_i;
            par_q   <= (^data_i) ^ odd_i ^ pe_i;
        end else begin
            if (bit_done || state_d != state_q) cnt_q <= '0;
            else if (baud_tick_i)               cnt_q <= cnt_q + CNT_W'(1);
            if (state_q == ST_DATA && bit_done) begin
                shreg_q <= shreg_q >> 1;
                idx_q   <= idx_q + IDX_W'(1);
            end
        end
    end

    always_comb begin
        txd_o   = 1'b1;
        tx_en_o = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_ALIGN: ;
            ST_START:  begin txd_o = 1'b0;       tx_en_o = 1'b1; end
            ST_DATA:   begin txd_o = shreg_q[0]; tx_en_o = 1'b1; end
            ST_PARITY: begin txd_o = par_q;      tx_en_o = 1'b1; end
            ST_STOP:   begin txd_o = 1'b1;       tx_en_o = 1'b1; end
            default: ;
        endcase
    end

    assert_mark_when_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en_o |-> txd_o);
    assert_disabled_stays_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !en_i) |=> (state_q == ST_IDLE));
    assert_ready_only_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> !tx_en_o);
    assert_half_stop_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP && cfg_q.fe_test && !cfg_q.sync_mode) |-> (cnt_q <= HALF_LAST));
    assert_no_sync_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.sync_mode && cfg_q.fe_test) |-> (state_q != ST_STOP));
    assert_cfg_frozen_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> (state_q == ST_IDLE || $stable(cfg_q)));
    assert_start_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en_o) |-> !txd_o);

endmodule

// File: rtl/usart_tx_inject.sv
module usart_tx_inject
    import usart_tx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        cfg_i,
    input  logic [DATA_W-1:0] tx_data_i,
    input  logic              tx_valid_i,
    output logic              tx_ready_o,
    input  logic              baud_tick_i,
    input  logic              rx_clk_i,
    output logic              txd_o,
    output logic              tx_en_o,
    output logic              tx_clk_o
);
    cfg_t cfg_w;
    logic cfg_unused;
    logic act_sync;
    logic act_clk_rx;
    logic bit_clk;
    logic fall_stb;

    assign cfg_w      = cfg_t'(cfg_i);
    assign cfg_unused = cfg_w.rsvd;

    usart_tx_clkgen #(.SYNC_STAGES(SYNC_STAGES)) u_clkgen (
        .clk         (clk),
        .rst_n       (rst_n),
        .baud_tick_i (baud_tick_i),
        .rx_clk_i    (rx_clk_i),
        .use_rx_i    (act_clk_rx),
        .bit_clk_o   (bit_clk),
        .fall_stb_o  (fall_stb)
    );

    usart_tx_fsm #(.DATA_W(DATA_W), .OVS(OVS)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_i         (cfg_w.enable),
        .sync_i       (cfg_w.sync_mode),
        .fe_i         (cfg_w.fe_test),
        .pe_i         (cfg_w.pe_test),
        .odd_i        (cfg_w.odd_par),
        .par_en_i     (cfg_w.par_en),
        .clk_rx_i     (cfg_w.clk_rx),
        .data_i       (tx_data_i),
        .valid_i      (tx_valid_i),
        .ready_o      (tx_ready_o),
        .baud_tick_i  (baud_tick_i),
        .fall_stb_i   (fall_stb),
        .act_sync_o   (act_sync),
        .act_clk_rx_o (act_clk_rx),
        .txd_o        (txd_o),
        .tx_en_o      (tx_en_o)
    );

    assign tx_clk_o = act_sync ? bit_clk : 1'b0;

    assert_async_clk_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !act_sync |-> !tx_clk_o);

endmodule

// File: tb/test_usart_tx_inject.sv
module test_usart_tx_inject;
    localparam int TICK_DIV = 3;
    localparam int RX_HALF  = 4;
    localparam int NVEC     = 12;

    // {cfg at accept, cfg written mid-frame, data}
    localparam logic [23:0] VEC [NVEC] = '{
        {8'h80, 8'h80, 8'h55},
        {8'h82, 8'h82, 8'hA3},
        {8'h86, 8'h86, 8'hA3},
        {8'h92, 8'h92, 8'h0F},
        {8'hA0, 8'hA0, 8'hFF},
        {8'h82, 8'hB6, 8'h3C},
        {8'hB6, 8'hB6, 8'h3C},
        {8'h81, 8'h81, 8'hC5},
        {8'h83, 8'h83, 8'h5A},
        {8'hA3, 8'hA3, 8'h96},
        {8'h93, 8'h80, 8'h01},
        {8'h8B, 8'h8B, 8'hE7}
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] cfg_i;
    logic [7:0] tx_data;
    logic       tx_valid;
    logic       tx_ready;
    logic       baud_tick;
    logic       rx_clk;
    logic       txd;
    logic       tx_en;
    logic       tx_clk;
    logic       tick_on = 1'b1;

    int n_chk = 0;
    int n_bad = 0;
    logic exp_bits [12];
    logic rec      [16];
    int   exp_n;
    logic has_stop;

    always #2 clk = ~clk;

    usart_tx_inject i_usart_tx_inject (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_i       (cfg_i),
        .tx_data_i   (tx_data),
        .tx_valid_i  (tx_valid),
        .tx_ready_o  (tx_ready),
        .baud_tick_i (baud_tick),
        .rx_clk_i    (rx_clk),
        .txd_o       (txd),
        .tx_en_o     (tx_en),
        .tx_clk_o    (tx_clk)
    );

    initial begin
        baud_tick = 1'b0;
        forever begin
            repeat (TICK_DIV - 1) @(posedge clk) baud_tick <= 1'b0;
            @(posedge clk) baud_tick <= tick_on;
        end
    end

    initial begin
        rx_clk = 1'b0;
        forever begin
            repeat (RX_HALF) @(posedge clk);
            rx_clk <= ~rx_clk;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic make_frame(input logic [7:0] cfg, input logic [7:0] d);
        exp_n = 0;
        exp_bits[exp_n] = 1'b0; exp_n++;
        for (int i = 0; i < 8; i++) begin
            exp_bits[exp_n] = d[i]; exp_n++;
        end
        if (cfg[1]) begin
            exp_bits[exp_n] = (^d) ^ cfg[2] ^ cfg[4]; exp_n++;
        end
        has_stop = !(cfg[0] && cfg[5]);
        if (has_stop) begin
            exp_bits[exp_n] = 1'b1; exp_n++;
        end
    endtask

    task automatic offer(input logic [7:0] cfg, input logic [7:0] d);
        @(negedge clk);
        cfg_i = cfg; tx_data = d; tx_valid = 1'b1;
        while (!tx_ready) @(negedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    // R3 R4 R5 R6 R8 R11 R12: async frame sampled once per baud tick.
    task automatic run_async(input logic [7:0] cfg, input logic [7:0] mid, input logic [7:0] d);
        int bad = 0, first_b = -1, act_v = 0, exp_v = 0;
        make_frame(cfg, d);
        offer(cfg, d);
        for (int b = 0; b < exp_n; b++) begin
            int dur = (has_stop && b == exp_n - 1 && cfg[5]) ? 8 : 16;
            for (int t = 0; t < dur; t++) begin
                while (!baud_tick) @(negedge clk);
                if (txd !== exp_bits[b] || tx_en !== 1'b1 || tx_clk !== 1'b0) begin
                    if (bad == 0) begin
                        first_b = b; act_v = {tx_clk, tx_en, txd}; exp_v = {2'b01, exp_bits[b]};
                    end
                    bad++;
                end
                if (b == 1 && t == 0) begin
                    check(tx_ready == 1'b0, "R11", "ready during frame", tx_ready, 0);
                    cfg_i = mid;
                end
                @(negedge clk);
            end
        end
        for (int t = 0; t < 3; t++) begin
            while (!baud_tick) @(negedge clk);
            if (txd !== 1'b1 || tx_en !== 1'b0) begin
                if (bad == 0) begin first_b = 99; act_v = {tx_en, txd}; exp_v = 1; end
                bad++;
            end
            @(negedge clk);
        end
        check(bad == 0, (cfg[5] ? "R6" : (cfg[4] ? "R8" : (cfg != mid ? "R12" : "R3/R4/R5"))),
              $sformatf("async frame cfg %0h data %0h bit %0d", cfg, d, first_b), act_v, exp_v);
    endtask

    // R3 R7 R9 R10 R12: sync frame sampled on rising edges of tx_clk.
    task automatic run_sync(input logic [7:0] cfg, input logic [7:0] mid, input logic [7:0] d);
        int got = 0, bad = 0, skew = 0;
        logic prev_clk, prev_txd, done;
        make_frame(cfg, d);
        tick_on = !cfg[3];
        offer(cfg, d);
        prev_clk = tx_clk; prev_txd = txd; done = 1'b0;
        for (int cyc = 0; cyc < 4000 && !done; cyc++) begin
            if (tx_en && txd !== prev_txd && !(prev_clk && !tx_clk)) skew++;
            if (tx_clk && !prev_clk) begin
                if (tx_en) begin
                    if (got < 16) rec[got] = txd;
                    got++;
                    if (got == 3) begin
                        check(tx_ready == 1'b0, "R11", "ready during sync frame", tx_ready, 0);
                        cfg_i = mid;
                    end
                end else if (got > 0) begin
                    done = 1'b1;
                end
            end
            prev_clk = tx_clk; prev_txd = txd;
            @(negedge clk);
        end
        for (int i = 0; i < exp_n && i < got && i < 16; i++)
            if (rec[i] !== exp_bits[i]) bad++;
        check(got == exp_n, (cfg[5] ? "R7" : "R9"),
              $sformatf("sync bit count cfg %0h", cfg), got, exp_n);
        check(bad == 0, (cfg[3] ? "R10" : (cfg != mid ? "R12" : "R3")),
              $sformatf("sync bit values cfg %0h data %0h", cfg, d), bad, 0);
        check(skew == 0, "R9", "txd changed away from tx_clk fall", skew, 0);
        tick_on = 1'b1;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog (all requirements): got timeout expected completion");
        finish_run();
    end

    initial begin
        int bad;
        rst_n = 1'b0; cfg_i = 8'h80; tx_data = '0; tx_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(txd == 1'b1 && tx_en == 1'b0 && tx_clk == 1'b0, "R1", "outputs in reset",
              {tx_clk, tx_en, txd}, 3'b001);
        rst_n = 1'b1;
        @(negedge clk);
        check(tx_ready == 1'b1 && txd == 1'b1 && tx_en == 1'b0, "R1", "idle after reset",
              {tx_ready, tx_en, txd}, 3'b101);

        for (int v = 0; v < NVEC; v++) begin
            if (VEC[v][16]) run_sync(VEC[v][23:16], VEC[v][15:8], VEC[v][7:0]);
            else            run_async(VEC[v][23:16], VEC[v][15:8], VEC[v][7:0]);
        end

        // R2: disabled port ignores an offered byte.
        @(negedge clk);
        cfg_i = 8'h00; tx_data = 8'h00; tx_valid = 1'b1;
        bad = 0;
        for (int c = 0; c < 200; c++) begin
            @(negedge clk);
            if (tx_ready || tx_en || !txd) bad++;
        end
        check(bad == 0, "R2", "activity while disabled", bad, 0);
        tx_valid = 1'b0;

        // R1: reset in mid-frame returns to idle and the frame is dropped.
        offer(8'h80, 8'h00);
        repeat (40) @(negedge clk);
        check(tx_en == 1'b1 && txd == 1'b0, "R1", "frame running before reset", {tx_en, txd}, 2'b10);
        rst_n = 1'b0;
        @(negedge clk);
        check(txd == 1'b1 && tx_en == 1'b0, "R1", "outputs at reset mid-frame", {tx_en, txd}, 2'b01);
        rst_n = 1'b1;
        bad = 0;
        for (int c = 0; c < 200; c++) begin
            @(negedge clk);
            if (tx_en || !txd) bad++;
        end
        check(bad == 0, "R1", "frame resumed after reset", bad, 0);

        finish_run();
    end

endmodule